// File: doc/BRIEF.md
# Touch Button Output Conditioner

This block sits between a capacitive touch front end and four active-low output pins, typically driving LEDs or signalling a host. It takes one debounced touch-status bit per button and turns it into an output level. The level follows the touch directly, or flips on each new touch in toggle mode. Three further features shape it. Neighbour suppression lets only one button report at a time. A shared post-release hold timer keeps a released button's output low for a while. A stuck-touch timeout turns an output off after a long continuous touch and then locks the button out for a short time after release.

Channels that failed the power-up self test arrive flagged on `diag_fail_i`. Each flagged channel gives one short active pulse shortly after reset and is disabled after that. All timing runs on a one-millisecond tick input. Every configuration input is captured on each clock edge while reset is asserted and on the first edge after release, and is then frozen until the next reset. All ports are plain control and status pins with no handshake, so there is no back-pressure.

Top module: `touch_gpo_cond`

## Requirements
- R1: In direct mode (`cfg_toggle_en`=0), `gpo_n[i]` is driven 0 from the clock edge after `touch_i[i]` is first sampled 1, and several buttons may be active together when suppression is off. With a hold time of zero, the output returns to 1 on the edge after release is sampled.
- R2: In toggle mode, each new touch of an enabled button inverts its output on the second clock edge after the touch is sampled. Releasing the button leaves the output unchanged. The output starts inactive (1) after reset.
- R3: With suppression on (`cfg_fss_en`=1), at most one button is reported at a time. A button already reported stays reported while it remains touched, even if others are touched too. When it is released, the lowest-numbered button still touched takes over.
- R4: With suppression on, when several buttons become touched in the same cycle and none was reported before, the lowest-numbered one wins.
- R5: In direct mode with `cfg_hold_steps`=N (0 to 100), a released button's output stays 0 for N*20 ticks after release and then returns to 1. N=0 gives no hold.
- R6: Only one hold runs at a time. When another button is released during a hold, the held output returns to 1 on the edge after that release is sampled, and the hold restarts for the newly released button.
- R7: In direct mode with `cfg_arst_en`=1, an output stays active for at most 5000 ticks of continuous touch, or 20000 ticks when `cfg_arst_long`=1. After that it reads 1 until release, and no hold is applied at that release.
- R8: After a timeout, the released button is ignored for 220 ticks if it was held less than 2000 ticks past the timeout, and for `cfg_scan_ms`+200 ticks otherwise.
- R9: A channel flagged in `diag_fail_i` drives 0 for exactly 5 ticks, starting at tick 10 after reset release and so well within 175 ticks. After that it stays 1 and its touches are ignored.
- R10: Configuration inputs changed after the first clock edge following reset release have no effect until the next reset.
- R11: While reset is asserted, all outputs read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| touch_i | input | NUM_BTN | Debounced touch status, 1 = touched |
| diag_fail_i | input | NUM_BTN | Power-up self-test failure flags, captured at reset |
| cfg_toggle_en | input | 1 | 1 = toggle mode, 0 = direct mode |
| cfg_fss_en | input | 1 | Neighbour suppression enable |
| cfg_hold_steps | input | HOLD_STEPS_W | Post-release hold in 20-tick steps |
| cfg_arst_en | input | 1 | Stuck-touch timeout enable |
| cfg_arst_long | input | 1 | 0 = 5000-tick timeout, 1 = 20000-tick timeout |
| cfg_scan_ms | input | SCAN_W | Scan period in ticks, used for the long lockout |
| gpo_n | output | NUM_BTN | Active-low outputs |

## Verification
The assertions check on every cycle the properties that hold in any state. Under suppression at most one button is reported. In toggle mode an output changes only after a new touch edge. A timed-out button that is still touched is never driven. A locked-out button never becomes reported. A failed channel stays inactive once its pulse window has passed. Only the directed scenarios can show the exact durations and orderings: the tick counts of the hold, timeout and two lockout lengths, preemption of the hold by a later release, winner hand-over, the lowest-index tie-break, and configuration being frozen after reset.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  typedef enum logic {
    OUT_DIRECT = 1'b0,
    OUT_TOGGLE = 1'b1
  } out_mode_e;

  // Fixed step of the hold-time setting, in ticks
  localparam int unsigned HOLD_STEP_TICKS = 20;
endpackage

// File: rtl/tgc_arbiter.sv
module tgc_arbiter #(
  parameter int unsigned NUM_BTN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fss_en,
  input  logic [NUM_BTN-1:0] touch_ok,
  output logic [NUM_BTN-1:0] rep_q
);
  logic [NUM_BTN-1:0] keep;
  logic [NUM_BTN-1:0] lowest;
  logic [NUM_BTN-1:0] rep_nxt;

  assign keep = rep_q & touch_ok;

  always_comb begin
    lowest = '0;
    for (int i = NUM_BTN - 1; i >= 0; i--) begin
      if (touch_ok[i]) begin
        lowest    = '0;
        lowest[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (!fss_en)     rep_nxt = touch_ok;
    else if (|keep)  rep_nxt = keep;
    else             rep_nxt = lowest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_nxt;
  end
endmodule

// File: rtl/tgc_chan_timer.sv
module tgc_chan_timer #(
  parameter int unsigned ARST_W        = 15,
  parameter int unsigned BLK_W         = 11,
  parameter int unsigned SCAN_W        = 10,
  parameter int unsigned SPLIT_MS      = 2000,
  parameter int unsigned BLK_SHORT_MS  = 220,
  parameter int unsigned BLK_EXTRA_MS  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic [ARST_W-1:0] period,
  input  logic [SCAN_W-1:0] scan_ms,
  input  logic              rep,
  input  logic              rel,
  output logic              tripped,
  output logic              blocked
);
  logic [ARST_W-1:0] held_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ARST_W-1:0] sat;
  logic              short_over;

  assign sat        = period + ARST_W'(SPLIT_MS);
  assign tripped    = en && (held_q >= period);
  assign blocked    = (blk_q != '0);
  assign short_over = (held_q - period) < ARST_W'(SPLIT_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      blk_q  <= '0;
    end else if (!en) begin
      held_q <= '0;
      blk_q  <= '0;
    end else begin
      if (!rep)                      held_q <= '0;
      else if (tick && held_q < sat) held_q <= held_q + 1'b1;

      if (rel && tripped)
        blk_q <= short_over ? BLK_W'(BLK_SHORT_MS)
                            : BLK_W'(scan_ms) + BLK_W'(BLK_EXTRA_MS);
      else if (tick && blk_q != '0)
        blk_q <= blk_q - 1'b1;
    end
  end
endmodule

// File: rtl/tgc_hold_timer.sv
module tgc_hold_timer #(
  parameter int unsigned NUM_BTN   = 4,
  parameter int unsigned HOLD_MS_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NUM_BTN-1:0]   start,
  input  logic [HOLD_MS_W-1:0] load_ms,
  output logic [NUM_BTN-1:0]   hold_drive
);
  logic                 vld_q;
  logic [NUM_BTN-1:0]   sel_q;
  logic [HOLD_MS_W-1:0] cnt_q;
  logic [NUM_BTN-1:0]   first;
  logic                 any_start;

  assign any_start = |start;

  always_comb begin
    first = '0;
    for (int i = NUM_BTN - 1; i >= 0; i--) begin
      if (start[i]) begin
        first    = '0;
        first[i] = 1'b1;
      end
    end
  end

  // A new release takes over in its own cycle, dropping the older hold
  assign hold_drive = (vld_q && !any_start) ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= '0;
      cnt_q <= '0;
    end else if (any_start) begin
      vld_q <= 1'b1;
      sel_q <= first;
      cnt_q <= load_ms - 1'b1;
    end else if (vld_q && tick) begin
      if (cnt_q <= HOLD_MS_W'(1)) vld_q <= 1'b0;
      else                        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/touch_gpo_cond.sv
module touch_gpo_cond
  import tgc_pkg::*;
#(
  parameter int unsigned NUM_BTN       = 4,
  parameter int unsigned HOLD_STEPS_W  = 7,
  parameter int unsigned SCAN_W        = 10,
  parameter int unsigned ARST_SHORT_MS = 5000,
  parameter int unsigned ARST_LONG_MS  = 20000,
  parameter int unsigned ARST_SPLIT_MS = 2000,
  parameter int unsigned BLK_SHORT_MS  = 220,
  parameter int unsigned BLK_EXTRA_MS  = 200,
  parameter int unsigned DIAG_START_MS = 10,
  parameter int unsigned DIAG_PULSE_MS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ms_tick,
  input  logic [NUM_BTN-1:0]      touch_i,
  input  logic [NUM_BTN-1:0]      diag_fail_i,
  input  logic                    cfg_toggle_en,
  input  logic                    cfg_fss_en,
  input  logic [HOLD_STEPS_W-1:0] cfg_hold_steps,
  input  logic                    cfg_arst_en,
  input  logic                    cfg_arst_long,
  input  logic [SCAN_W-1:0]       cfg_scan_ms,
  output logic [NUM_BTN-1:0]      gpo_n
);
  localparam int unsigned HOLD_MS_W = $clog2(((1 << HOLD_STEPS_W) - 1) * HOLD_STEP_TICKS + 1);
  localparam int unsigned ARST_W    = $clog2(ARST_LONG_MS + ARST_SPLIT_MS + 1);
  localparam int unsigned BLK_W     = $clog2((1 << SCAN_W) + BLK_EXTRA_MS + BLK_SHORT_MS);
  localparam int unsigned DIAG_END  = DIAG_START_MS + DIAG_PULSE_MS;
  localparam int unsigned DIAG_W    = $clog2(DIAG_END + 1);

  // Configuration capture: follows the inputs during reset and on the
  // first edge after release, then frozen
  logic                 cfg_ld;
  out_mode_e            mode_q;
  logic                 fss_q;
  logic                 arst_q;
  logic [HOLD_MS_W-1:0] hold_ms_q;
  logic [ARST_W-1:0]    period_q;
  logic [SCAN_W-1:0]    scan_q;
  logic [NUM_BTN-1:0]   fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ld <= 1'b0;
    else        cfg_ld <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!cfg_ld) begin
      mode_q    <= cfg_toggle_en ? OUT_TOGGLE : OUT_DIRECT;
      fss_q     <= cfg_fss_en;
      arst_q    <= cfg_arst_en;
      hold_ms_q <= HOLD_MS_W'(cfg_hold_steps) * HOLD_MS_W'(HOLD_STEP_TICKS);
      period_q  <= cfg_arst_long ? ARST_W'(ARST_LONG_MS) : ARST_W'(ARST_SHORT_MS);
      scan_q    <= cfg_scan_ms;
      fail_q    <= diag_fail_i;
    end
  end

  logic direct;
  assign direct = (mode_q == OUT_DIRECT);

  // Report stage
  logic [NUM_BTN-1:0] tripped;
  logic [NUM_BTN-1:0] blocked;
  logic [NUM_BTN-1:0] touch_ok;
  logic [NUM_BTN-1:0] rep_q;
  logic [NUM_BTN-1:0] rep_d;
  logic [NUM_BTN-1:0] rise;
  logic [NUM_BTN-1:0] rel;

  assign touch_ok = touch_i & ~fail_q & ~blocked;

  tgc_arbiter #(.NUM_BTN(NUM_BTN)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fss_en   (fss_q),
    .touch_ok (touch_ok),
    .rep_q    (rep_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_d <= '0;
    else        rep_d <= rep_q;
  end

  assign rise = rep_q & ~rep_d;
  assign rel  = rep_d & ~rep_q;

  // Per-channel stuck-touch timeout and lockout
  for (genvar g = 0; g < NUM_BTN; g++) begin : g_chan
    tgc_chan_timer #(
      .ARST_W       (ARST_W),
      .BLK_W        (BLK_W),
      .SCAN_W       (SCAN_W),
      .SPLIT_MS     (ARST_SPLIT_MS),
      .BLK_SHORT_MS (BLK_SHORT_MS),
      .BLK_EXTRA_MS (BLK_EXTRA_MS)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ms_tick),
      .en      (arst_q && direct),
      .period  (period_q),
      .scan_ms (scan_q),
      .rep     (rep_q[g]),
      .rel     (rel[g]),
      .tripped (tripped[g]),
      .blocked (blocked[g])
    );
  end

  // Shared post-release hold
  logic [NUM_BTN-1:0] hold_start;
  logic [NUM_BTN-1:0] hold_drive;

  assign hold_start = (direct && hold_ms_q != '0) ? (rel & ~tripped) : '0;

  tgc_hold_timer #(.NUM_BTN(NUM_BTN), .HOLD_MS_W(HOLD_MS_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ms_tick),
    .start      (hold_start),
    .load_ms    (hold_ms_q),
    .hold_drive (hold_drive)
  );

  // Toggle state
  logic [NUM_BTN-1:0] tog_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= '0;
    else if (!direct) tog_q <= tog_q ^ rise;
  end

  // Self-test failure pulse window
  logic [DIAG_W-1:0] diag_cnt;
  logic              diag_pulse;
  logic              diag_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  diag_cnt <= '0;
    else if (ms_tick && diag_cnt < DIAG_W'(DIAG_END)) diag_cnt <= diag_cnt + 1'b1;
  end

  assign diag_pulse = (diag_cnt >= DIAG_W'(DIAG_START_MS)) && (diag_cnt < DIAG_W'(DIAG_END));
  assign diag_done  = (diag_cnt >= DIAG_W'(DIAG_END));

  // Output
  logic [NUM_BTN-1:0] drive;
  always_comb begin
    if (direct) drive = (rep_q & ~tripped) | hold_start | hold_drive;
    else        drive = tog_q;
    drive = drive | (fail_q & {NUM_BTN{diag_pulse}});
  end

  assign gpo_n = ~drive;
endmodule

// File: rtl/tgc_checks.sv
module tgc_checks #(
  parameter int unsigned NUM_BTN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_ld,
  input logic               direct,
  input logic               fss_q,
  input logic [NUM_BTN-1:0] fail_q,
  input logic               diag_done,
  input logic [NUM_BTN-1:0] rep_q,
  input logic [NUM_BTN-1:0] rep_d,
  input logic [NUM_BTN-1:0] tripped,
  input logic [NUM_BTN-1:0] blocked,
  input logic [NUM_BTN-1:0] gpo_n
);
  assert_one_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ld && fss_q) |-> $onehot0(rep_q));

  assert_toggle_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ld && $past(cfg_ld) && !direct) |->
      (((gpo_n ^ $past(gpo_n)) & ~fail_q & ~($past(rep_q) & ~$past(rep_d))) == '0));

  assert_timeout_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ld && direct) |-> ((~gpo_n & rep_q & tripped & ~fail_q) == '0));

  assert_lockout_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |-> ((blocked & $past(blocked) & rep_q) == '0));

  assert_failed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ld && diag_done) |-> ((~gpo_n & fail_q) == '0));
endmodule

bind touch_gpo_cond tgc_checks #(.NUM_BTN(NUM_BTN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_ld    (cfg_ld),
  .direct    (direct),
  .fss_q     (fss_q),
  .fail_q    (fail_q),
  .diag_done (diag_done),
  .rep_q     (rep_q),
  .rep_d     (rep_d),
  .tripped   (tripped),
  .blocked   (blocked),
  .gpo_n     (gpo_n)
);

// File: tb/touch_gpo_cond_tb.sv
module touch_gpo_cond_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b1;
  logic [3:0] touch_i = '0;
  logic [3:0] diag_fail_i = '0;
  logic       cfg_toggle_en = 1'b0;
  logic       cfg_fss_en = 1'b0;
  logic [6:0] cfg_hold_steps = '0;
  logic       cfg_arst_en = 1'b0;
  logic       cfg_arst_long = 1'b0;
  logic [9:0] cfg_scan_ms = '0;
  logic [3:0] gpo_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  touch_gpo_cond u_dut (
    .clk (clk), .rst_n (rst_n), .ms_tick (ms_tick), .touch_i (touch_i),
    .diag_fail_i (diag_fail_i), .cfg_toggle_en (cfg_toggle_en),
    .cfg_fss_en (cfg_fss_en), .cfg_hold_steps (cfg_hold_steps),
    .cfg_arst_en (cfg_arst_en), .cfg_arst_long (cfg_arst_long),
    .cfg_scan_ms (cfg_scan_ms), .gpo_n (gpo_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gpo_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit tog, input bit fss, input int hold, input bit arst,
                          input bit lng, input int scan, input logic [3:0] fail);
    touch_i        = '0;
    cfg_toggle_en  = tog;
    cfg_fss_en     = fss;
    cfg_hold_steps = 7'(hold);
    cfg_arst_en    = arst;
    cfg_arst_long  = lng;
    cfg_scan_ms    = 10'(scan);
    diag_fail_i    = fail;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    touch_i = 4'hF;
    step(3);
    chk("R11 outputs idle in reset", gpo_n, 4'b1111);
    touch_i = '0;
  endtask

  task automatic t_direct;
    do_reset(0, 0, 0, 0, 0, 30, 4'b0000);
    touch_i = 4'b0001; step(1);
    chk("R1 direct touch ch0", gpo_n, 4'b1110);
    touch_i = 4'b1011; step(1);
    chk("R1 several active without suppression", gpo_n, 4'b0100);
    touch_i = '0; step(1);
    chk("R1 release with zero hold", gpo_n, 4'b1111);
  endtask

  task automatic t_toggle;
    do_reset(1, 0, 3, 0, 0, 30, 4'b0000);
    touch_i = 4'b0001; step(2);
    chk("R2 first touch turns on", gpo_n, 4'b1110);
    touch_i = '0; step(5);
    chk("R2 state kept after release", gpo_n, 4'b1110);
    touch_i = 4'b0001; step(2);
    chk("R2 second touch turns off", gpo_n, 4'b1111);
    touch_i = '0; step(3);
  endtask

  task automatic t_fss;
    do_reset(0, 1, 0, 0, 0, 30, 4'b0000);
    touch_i = 4'b0100; step(1);
    chk("R3 single touch reported", gpo_n, 4'b1011);
    touch_i = 4'b0110; step(3);
    chk("R3 earlier button keeps report", gpo_n, 4'b1011);
    touch_i = 4'b0010; step(1);
    chk("R3 hand-over to remaining button", gpo_n, 4'b1101);
    touch_i = '0; step(2);
    touch_i = 4'b1010; step(1);
    chk("R4 simultaneous touch lowest wins", gpo_n, 4'b1101);
    touch_i = '0; step(2);
  endtask

  task automatic t_hold;
    do_reset(0, 0, 1, 0, 0, 30, 4'b0000);
    touch_i = 4'b1000; step(4);
    touch_i = '0; step(20);
    chk("R5 hold still active at 20 ticks", gpo_n, 4'b0111);
    step(1);
    chk("R5 hold ends after 20 ticks", gpo_n, 4'b1111);
  endtask

  task automatic t_preempt;
    do_reset(0, 0, 5, 0, 0, 30, 4'b0000);
    touch_i = 4'b0011; step(5);
    touch_i = 4'b0010; step(10);
    chk("R6 first hold running", gpo_n, 4'b1100);
    touch_i = '0; step(1);
    chk("R6 later release preempts hold", gpo_n, 4'b1101);
    step(99);
    chk("R6 restarted hold still on", gpo_n, 4'b1101);
    step(1);
    chk("R6 restarted hold ends", gpo_n, 4'b1111);
  endtask

  task automatic t_arst(input bit go_long);
    do_reset(0, 0, 1, 1, 0, 30, 4'b0000);
    touch_i = 4'b0001; step(5000);
    chk("R7 active up to period", gpo_n, 4'b1110);
    step(1);
    chk("R7 inactive after period", gpo_n, 4'b1111);
    step(go_long ? 2100 : 100);
    touch_i = '0; step(1);
    chk("R7 no hold after timeout", gpo_n, 4'b1111);
    step(4);
    chk("R7 no hold after timeout later", gpo_n, 4'b1111);
    touch_i = 4'b0001;
    step(go_long ? 227 : 217);
    chk(go_long ? "R8 long lockout still active" : "R8 short lockout still active", gpo_n, 4'b1111);
    step(1);
    chk(go_long ? "R8 long lockout ends" : "R8 short lockout ends", gpo_n, 4'b1110);
    touch_i = '0; step(30);
  endtask

  task automatic t_arst_long_period;
    do_reset(0, 0, 0, 1, 1, 30, 4'b0000);
    touch_i = 4'b0100; step(20000);
    chk("R7 long period still active", gpo_n, 4'b1011);
    step(1);
    chk("R7 long period expired", gpo_n, 4'b1111);
    touch_i = '0; step(300);
  endtask

  task automatic t_diag;
    int lows;
    int first;
    int other;
    do_reset(0, 0, 0, 0, 0, 30, 4'b0100);
    lows = 0; first = -1; other = 0;
    for (int i = 0; i < 200; i++) begin
      if (gpo_n[2] == 1'b0) begin
        lows++;
        if (first < 0) first = i;
      end
      if (gpo_n[0] == 1'b0) other++;
      step(1);
    end
    chk_int("R9 failed channel pulse length", lows, 5);
    chk_int("R9 pulse starts within 175 ticks", (first >= 0 && first <= 175) ? 1 : 0, 1);
    chk_int("R9 healthy channel has no pulse", other, 0);
    touch_i = 4'b0101; step(3);
    chk("R9 failed channel ignores touch", gpo_n, 4'b1110);
    touch_i = '0; step(2);
  endtask

  task automatic t_cfg_freeze;
    do_reset(0, 0, 0, 0, 0, 30, 4'b0000);
    step(2);
    cfg_toggle_en = 1'b1;
    cfg_hold_steps = 7'd5;
    cfg_fss_en = 1'b1;
    touch_i = 4'b0011; step(1);
    chk("R10 mode frozen after reset", gpo_n, 4'b1100);
    touch_i = '0; step(1);
    chk("R10 hold frozen after reset", gpo_n, 4'b1111);
  endtask

  initial begin
    t_reset_state();
    t_direct();
    t_toggle();
    t_fss();
    t_hold();
    t_preempt();
    t_arst(1'b0);
    t_arst(1'b1);
    t_arst_long_period();
    t_diag();
    t_cfg_freeze();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule